// File: doc/BRIEF.md
# Modem-Line Control with Change Interrupts

This block is the modem-control corner of a serial port. It drives the two outgoing handshake lines (data-terminal-ready and request-to-send) from bits in a control register, with each pin showing the inverse of its bit. It brings the four incoming lines (ring indicator, clear-to-send, carrier detect, data-set-ready) through a two-stage synchronizer and exposes their levels in a line-status register.

A change on clear-to-send or carrier detect sets a per-line pending flag. Each line has its own configuration bit that selects between "falling edge only" and "either edge". Reading the line-status register returns the flags and then clears them, unless a new edge lands in the same cycle. A summary status bit combines the per-line flags after the per-line masks, and a separate summary mask gates the interrupt output that feeds the port's main interrupt logic.

A loopback control bit sends the transmitter's serial output straight to the receiver's serial input and holds the outgoing data pin idle-high.

Top module: `mdm_line_ctrl`

## Requirements
- R1: The control register at address 0 holds bit 0 (terminal-ready), bit 1 (request-to-send) and bit 2 (loopback) and reads back as written. `dtr_pin_o` equals the inverse of bit 0 and `rts_pin_o` equals the inverse of bit 1, one clock after the write. Reset clears all three bits.
- R2: Line-status register (address 1) bits 0..3 show the ring, clear-to-send, carrier and data-set-ready input levels. A new input level appears after exactly two rising clock edges, and not after one.
- R3: The edge-config register at address 2 has bit 0 (clear-to-send mask), bit 1 (carrier mask), bit 2 (clear-to-send any-edge) and bit 3 (carrier any-edge). With the any-edge bit set, both a rising and a falling change on that line set its flag. The flags are line-status bit 4 (clear-to-send) and bit 5 (carrier).
- R4: With the any-edge bit clear, only a 1-to-0 change sets the line's flag. A rising change leaves the flag clear.
- R5: A read of address 1 with `rd_en_i` high returns the flags as they stand and clears them for the next cycle. A read of any other address leaves the flags alone.
- R6: If a flag-setting change falls in the same cycle as a clearing read, the flag is set afterwards.
- R7: Register address 3 bit 0 is the summary mask (read/write). Bit 1 reads the summary status: (clear-to-send flag AND its mask) OR (carrier flag AND its mask). `ext_irq_o` equals the summary status AND the summary mask.
- R8: With loopback set, `ser_rx_o` follows `ser_tx_i`, `txd_pin_o` is held at 1, and `rxd_pin_i` has no effect. With loopback clear, `ser_rx_o` follows `rxd_pin_i` and `txd_pin_o` follows `ser_tx_i`.
- R9: Writes to address 1 change no register. Edge-config and summary-mask registers read back as written and reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (clears flags on address 1) |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| line_ri_i | input | 1 | Ring-indicator input |
| line_cts_i | input | 1 | Clear-to-send input |
| line_dcd_i | input | 1 | Carrier-detect input |
| line_dsr_i | input | 1 | Data-set-ready input |
| dtr_pin_o | output | 1 | Terminal-ready pin, inverse of its bit |
| rts_pin_o | output | 1 | Request-to-send pin, inverse of its bit |
| ext_irq_o | output | 1 | Masked summary interrupt |
| ser_tx_i | input | 1 | Serial data from the transmitter |
| ser_rx_o | output | 1 | Serial data to the receiver |
| txd_pin_o | output | 1 | Outgoing data pin |
| rxd_pin_i | input | 1 | Incoming data pin |

## Verification
The level path is swept through all sixteen input combinations, sampled after one and after two edges, which separates a correct two-stage latency from a short or long one. Edge sensing is tried for each changing line, each any-edge setting and both directions, which separates "falling only" from "either edge" and shows that the lines do not leak into each other. The summary path is swept over every combination of the two flags, the two line masks and the summary mask. A read that coincides with a new change is compared against a plain read and a read of a neighbouring address, which tells clearing apart from edge-preserving behaviour.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int N_LINES  = 4;
    localparam int N_WATCH  = 2;

    localparam int LN_RI  = 0;
    localparam int LN_CTS = 1;
    localparam int LN_DCD = 2;
    localparam int LN_DSR = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTL   = 2'd0,
        ADR_LINES = 2'd1,
        ADR_EDGE  = 2'd2,
        ADR_TOP   = 2'd3
    } reg_addr_e;

    // watched line g maps to input line index
    function automatic int watch_line(input int g);
        return (g == 0) ? LN_CTS : LN_DCD;
    endfunction
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] lvl_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = raw_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.chain[STAGES-1];
endmodule

// File: rtl/mdm_edge_flag.sv
module mdm_edge_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic any_i,
    input  logic clr_i,
    output logic pend_o
);
    typedef struct packed {
        logic prev;
        logic pend;
    } edge_t;

    edge_t st_d, st_q;
    logic  hit_w;

    always_comb begin
        st_d      = st_q;
        hit_w     = any_i ? (st_q.prev ^ lvl_i) : (st_q.prev & ~lvl_i);
        st_d.prev = lvl_i;
        st_d.pend = (st_q.pend & ~clr_i) | hit_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    AST_ANY_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (any_i && (st_q.prev != lvl_i)) |=> pend_o); // R3
    AST_RISE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_i && !pend_o && !(st_q.prev && !lvl_i)) |=> !pend_o); // R4
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit_w) |=> !pend_o); // R5
    AST_EDGE_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && hit_w) |=> pend_o); // R6
endmodule

// File: rtl/mdm_regs.sv
module mdm_regs
    import mdm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic                 rd_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    input  logic [N_LINES-1:0]   lvl_i,
    input  logic [N_WATCH-1:0]   pend_i,
    output logic [N_WATCH-1:0]   any_edge_o,
    output logic                 clr_o,
    output logic                 dtr_bit_o,
    output logic                 rts_bit_o,
    output logic                 loop_o,
    output logic                 irq_o
);
    typedef struct packed {
        logic [2:0]         ctl;
        logic [N_WATCH-1:0] lmask;
        logic [N_WATCH-1:0] anye;
        logic               smask;
    } regs_t;

    regs_t rg_d, rg_q;
    logic  sum_w;
    logic  unused_wdata;

    assign unused_wdata = ^wdata_i[DATA_W-1:4];

    always_comb begin
        rg_d = rg_q;
        if (wr_en_i) begin
            unique case (reg_addr_e'(addr_i))
                ADR_CTL:  rg_d.ctl = wdata_i[2:0];
                ADR_EDGE: begin
                    rg_d.lmask = wdata_i[N_WATCH-1:0];
                    rg_d.anye  = wdata_i[2*N_WATCH-1:N_WATCH];
                end
                ADR_TOP:  rg_d.smask = wdata_i[0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign sum_w = |(pend_i & rg_q.lmask);

    always_comb begin
        rdata_o = '0;
        unique case (reg_addr_e'(addr_i))
            ADR_CTL:   rdata_o[2:0] = rg_q.ctl;
            ADR_LINES: rdata_o[N_LINES+N_WATCH-1:0] = {pend_i, lvl_i};
            ADR_EDGE:  rdata_o[2*N_WATCH-1:0] = {rg_q.anye, rg_q.lmask};
            ADR_TOP:   rdata_o[1:0] = {sum_w, rg_q.smask};
            default:   ;
        endcase
    end

    assign clr_o      = rd_en_i && (reg_addr_e'(addr_i) == ADR_LINES);
    assign any_edge_o = rg_q.anye;
    assign dtr_bit_o  = rg_q.ctl[0];
    assign rts_bit_o  = rg_q.ctl[1];
    assign loop_o     = rg_q.ctl[2];
    assign irq_o      = sum_w & rg_q.smask;

    AST_LINES_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && reg_addr_e'(addr_i) == ADR_LINES) |=> (rg_q == $past(rg_q))); // R9
endmodule

// File: rtl/mdm_line_ctrl.sv
module mdm_line_ctrl
    import mdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              line_ri_i,
    input  logic              line_cts_i,
    input  logic              line_dcd_i,
    input  logic              line_dsr_i,
    output logic              dtr_pin_o,
    output logic              rts_pin_o,
    output logic              ext_irq_o,
    input  logic              ser_tx_i,
    output logic              ser_rx_o,
    output logic              txd_pin_o,
    input  logic              rxd_pin_i
);
    logic [N_LINES-1:0] raw_w, lvl_w;
    logic [N_WATCH-1:0] pend_w, any_w;
    logic clr_w, dtr_bit_w, rts_bit_w, loop_w;

    always_comb begin
        raw_w          = '0;
        raw_w[LN_RI]   = line_ri_i;
        raw_w[LN_CTS]  = line_cts_i;
        raw_w[LN_DCD]  = line_dcd_i;
        raw_w[LN_DSR]  = line_dsr_i;
    end

    mdm_sync #(.WIDTH(N_LINES), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (raw_w),
        .lvl_o (lvl_w)
    );

    for (genvar g = 0; g < N_WATCH; g++) begin : g_watch
        mdm_edge_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (lvl_w[watch_line(g)]),
            .any_i  (any_w[g]),
            .clr_i  (clr_w),
            .pend_o (pend_w[g])
        );
    end

    mdm_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .rd_en_i    (rd_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .rdata_o    (rdata_o),
        .lvl_i      (lvl_w),
        .pend_i     (pend_w),
        .any_edge_o (any_w),
        .clr_o      (clr_w),
        .dtr_bit_o  (dtr_bit_w),
        .rts_bit_o  (rts_bit_w),
        .loop_o     (loop_w),
        .irq_o      (ext_irq_o)
    );

    assign dtr_pin_o = ~dtr_bit_w;
    assign rts_pin_o = ~rts_bit_w;
    assign ser_rx_o  = loop_w ? ser_tx_i : rxd_pin_i;
    assign txd_pin_o = loop_w ? 1'b1     : ser_tx_i;

    AST_PIN_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADR_CTL) |=>
        (dtr_pin_o == !$past(wdata_i[0])) && (rts_pin_o == !$past(wdata_i[1]))); // R1
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ext_irq_o |-> (|pend_w)); // R7
    AST_LOOP_IDLE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        loop_w |-> (txd_pin_o && (ser_rx_o == ser_tx_i))); // R8
endmodule

// File: tb/sim_mdm_line_ctrl.sv
module sim_mdm_line_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic [3:0] lines = '0;
    logic       dtr_pin, rts_pin, ext_irq;
    logic       ser_tx = 1'b0, ser_rx, txd_pin, rxd_pin = 1'b0;
    int         checks = 0, fails = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdm_line_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .line_ri_i(lines[0]), .line_cts_i(lines[1]),
        .line_dcd_i(lines[2]), .line_dsr_i(lines[3]),
        .dtr_pin_o(dtr_pin), .rts_pin_o(rts_pin), .ext_irq_o(ext_irq),
        .ser_tx_i(ser_tx), .ser_rx_o(ser_rx), .txd_pin_o(txd_pin),
        .rxd_pin_i(rxd_pin)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; #1 v = rdata;
    endtask

    task automatic rdclr(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; rd_en = 1'b1; #1 v = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [3:0] prev;
        step(3);
        rst_n = 1'b1;
        step(1);
        // reset state R1 R9
        chk("R1 reset dtr pin", {7'b0, dtr_pin}, 8'h01);
        chk("R1 reset rts pin", {7'b0, rts_pin}, 8'h01);
        peek(2'd0, v); chk("R1 reset ctl", v, 8'h00);
        peek(2'd2, v); chk("R9 reset edge cfg", v, 8'h00);
        peek(2'd3, v); chk("R9 reset top", v, 8'h00);
        chk("R7 reset irq", {7'b0, ext_irq}, 8'h00);

        // R1 and R8: control sweep with loopback data sweep
        for (int c = 0; c < 8; c++) begin
            wr(2'd0, 8'(c));
            peek(2'd0, v); chk("R1 ctl readback", v, 8'(c));
            chk("R1 dtr pin", {7'b0, dtr_pin}, {7'b0, ~c[0]});
            chk("R1 rts pin", {7'b0, rts_pin}, {7'b0, ~c[1]});
            for (int s = 0; s < 4; s++) begin
                @(negedge clk); ser_tx = s[0]; rxd_pin = s[1]; #1;
                chk("R8 rx path", {7'b0, ser_rx}, {7'b0, c[2] ? s[0] : s[1]});
                chk("R8 tx pin", {7'b0, txd_pin}, {7'b0, c[2] ? 1'b1 : s[0]});
            end
        end
        wr(2'd0, 8'h00);

        // R9: readback and ignored write to line-status address
        for (int e = 0; e < 16; e++) begin
            wr(2'd2, 8'(e)); peek(2'd2, v); chk("R9 edge cfg readback", v, 8'(e));
        end
        wr(2'd3, 8'h01); peek(2'd3, v); chk("R9 top mask readback", v & 8'h01, 8'h01);
        wr(2'd0, 8'h03); wr(2'd1, 8'hFF);
        peek(2'd0, v); chk("R9 ctl after lines write", v, 8'h03);
        peek(2'd3, v); chk("R9 top after lines write", v & 8'h01, 8'h01);
        peek(2'd2, v); chk("R9 edge after lines write", v, 8'h0F);
        wr(2'd0, 8'h00); wr(2'd3, 8'h00); wr(2'd2, 8'h00);

        // R2: level sweep with latency check
        prev = lines;
        for (int n = 0; n < 16; n++) begin
            @(negedge clk); lines = 4'(n ^ (n >> 1));
            peek(2'd1, v); chk("R2 level after one edge", v & 8'h0F, {4'b0, prev});
            peek(2'd1, v); chk("R2 level after two edges", v & 8'h0F, {4'b0, lines});
            prev = lines;
        end
        @(negedge clk); lines = '0; step(4);

        // R3 R4: edge sweep per line, mode, direction
        for (int ln = 0; ln < 2; ln++) begin
            for (int any = 0; any < 2; any++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    wr(2'd2, 8'(any << (2 + ln)));
                    @(negedge clk); lines[1+ln] = dir[0];
                    step(4); rdclr(2'd1, v);
                    @(negedge clk); lines[1+ln] = ~dir[0];
                    step(4); peek(2'd1, v);
                    chk(any ? "R3 any-edge flag" : "R4 falling-only flag",
                        (v >> (4 + ln)) & 8'h01, 8'((any | dir) & 1));
                    chk("R3 other line flag quiet", (v >> (5 - ln)) & 8'h01, 8'h00);
                end
            end
        end
        @(negedge clk); lines = '0; step(4); rdclr(2'd1, v);

        // R5: clear-on-read, other address does not clear
        wr(2'd2, 8'h0C);
        @(negedge clk); lines[1] = 1'b1; step(4);
        rdclr(2'd0, v);
        peek(2'd1, v); chk("R5 flag kept after other read", v & 8'h10, 8'h10);
        rdclr(2'd1, v); chk("R5 read returns flag", v & 8'h10, 8'h10);
        peek(2'd1, v); chk("R5 flag cleared by read", v & 8'h30, 8'h00);

        // R6: carrier change meets clearing read in the same cycle
        @(negedge clk); lines[2] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); addr = 2'd1; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        peek(2'd1, v); chk("R6 coincident edge kept", v & 8'h20, 8'h20);
        rdclr(2'd1, v);
        peek(2'd1, v); chk("R6 later plain read clears", v & 8'h20, 8'h00);

        // R7: summary and interrupt sweep
        for (int p = 0; p < 4; p++) begin
            for (int m = 0; m < 4; m++) begin
                for (int x = 0; x < 2; x++) begin
                    logic sum;
                    wr(2'd2, 8'(8'h0C | m));
                    wr(2'd3, 8'(x));
                    rdclr(2'd1, v);
                    @(negedge clk);
                    if (p[0]) lines[1] = ~lines[1];
                    if (p[1]) lines[2] = ~lines[2];
                    step(4);
                    sum = (p[0] & m[0]) | (p[1] & m[1]);
                    peek(2'd3, v);
                    chk("R7 summary status", v & 8'h03, {6'b0, sum, x[0]});
                    chk("R7 interrupt output", {7'b0, ext_irq}, {7'b0, sum & x[0]});
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule